// File: doc/BRIEF.md
# Laser Drive Safety Controller

This block governs the light source of an optical motion sensor. Four configuration registers are held as two true/complement pairs: a control pair that selects the current range, the laser bin match and the drive mode, and a current pair that holds the drive current code. The laser is driven only while both pairs agree bit for bit with their complements. In pulsed mode a drive pulse follows each frame request. In calibration mode the drive stays on continuously.

Safety is enforced in two ways. A comparator input reports that the drive pin has been pulled toward ground. Outside the self-test window this latches a fault, which cuts the drive and raises the active-low supply enable of an external power switch until reset. Every few frames, one frame slot is spent on a self-test instead of a pulse. The supply is switched off, an internal pull to ground is asserted, and the comparator must report the low pin within a bounded number of cycles. If it does not, for example because the pin is shorted to the supply, the fault is latched.

A shutdown input holds the drive and the supply switch off and freezes frame handling. All outputs are registered. The comparator input is synchronised before use.

Top module: `laser_safety_ctrl`

## Requirements
- R1: While `rst` is high, `drive_en`, `selftest_pull`, `fault_latched` and `cfg_mismatch` are 0 and `supply_en_n` is 1. In the first cycle after reset is released with no shutdown, `supply_en_n` is 0.
- R2: Write select 0 is the control register (reset 0x00), 1 its complement (reset 0x01), 2 the current code (reset 0x00) and 3 its complement (reset 0x00). The control pair agrees when bits 7, 5, 3, 2 and 1 of the complement are the inverse of the same bits of the control register. The current pair agrees when the complement is the bitwise inverse of the code. The reset values therefore do not agree, and the laser is not driven.
- R3: In the cycle after a frame strobe is accepted in idle with both pairs agreeing and calibration off, `drive_en` rises and stays high for `PULSE_LEN` cycles. During the pulse, `drive_code` shows the current register and `drive_range_hi` shows control bit 7.
- R4: When control bits [3:1] are all 1 and both pairs agree, `drive_en` is held high continuously while idle. It rises one cycle after the cycle in which the registers come to agree.
- R5: A frame strobe accepted while either pair disagrees produces no pulse and sets `cfg_mismatch`, which stays set until reset. Pulses resume as soon as the pairs agree again.
- R6: When the synchronised comparator input is high while idle or pulsing and not in shutdown, `fault_latched` is set. From then until reset, `drive_en` is 0 and `supply_en_n` is 1.
- R7: Every `SELFTEST_PERIOD`-th accepted frame strobe starts a self-test instead of a pulse. `selftest_pull` and `supply_en_n` go high and `drive_en` goes low. When the low pin is seen, the pull is released, the supply stays off for a settling time, and normal operation returns with no fault.
- R8: If the comparator does not report the low pin within `TEST_WAIT` cycles of self-test start, `fault_latched` is set.
- R9: While `shutdown` is high, `drive_en` and `selftest_pull` are 0 from the next cycle, `supply_en_n` is 1, and frame strobes are neither served nor counted.
- R10: Whenever `drive_en` is 0, `drive_code` is 0 and `drive_range_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| frame_strobe | input | 1 | One-cycle request for a frame pulse |
| shutdown | input | 1 | Holds the laser and supply off |
| pin_low | input | 1 | Comparator: drive pin pulled low (asynchronous) |
| drive_en | output | 1 | Drive current enable |
| drive_code | output | 8 | Drive current code, 0 when idle |
| drive_range_hi | output | 1 | High current range select, 0 when idle |
| supply_en_n | output | 1 | Active-low enable for the external supply switch |
| selftest_pull | output | 1 | Internal pull of the drive pin to ground |
| fault_latched | output | 1 | Sticky pin fault |
| cfg_mismatch | output | 1 | Sticky record of a frame refused for disagreeing pairs |

## Verification
The main function is tried with agreeing and disagreeing pairs. A default-valued pair and a pair whose bin bit alone disagrees separate the full-compare path from the masked control compare. Pulsed and calibration settings show whether frame requests or the mode bits govern the drive. Self-tests are tried with a responding pin and with a pin stuck high, which separates a passing test from a missing response. A comparator report injected while idle, and shutdown applied during continuous drive, show that each of those paths alone turns the supply off.

// File: rtl/laser_safety_pkg.sv
package laser_safety_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 4;
  localparam int SEL_W    = 2;

  // field positions decoded by the drive sequencer
  localparam int RANGE_BIT = 7;
  localparam int CAL_LO    = 1;
  localparam int CAL_HI    = 3;

  // control bits that must be inverted in the complement register
  localparam logic [REG_W-1:0] CTRL_CHECK_MASK = 8'hAE;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL     = 2'd0,
    SEL_CTRL_INV = 2'd1,
    SEL_CUR      = 2'd2,
    SEL_CUR_INV  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_TEST   = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic             pair_ok;
    logic             cal_mode;
    logic             range_hi;
    logic [REG_W-1:0] code;
  } cfg_view_t;

  function automatic logic [REG_W-1:0] reg_default(int idx);
    case (idx)
      1:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/laser_cfg_regs.sv
module laser_cfg_regs
  import laser_safety_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output cfg_view_t        view
);

  logic [REG_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else if (wr_en) begin
      regs[wr_sel] <= wr_data;
    end
  end

  logic [REG_W-1:0] ctrl_q, ctrl_inv_q, cur_q, cur_inv_q;
  logic             ctrl_agree, cur_agree;

  assign ctrl_q     = regs[int'(SEL_CTRL)];
  assign ctrl_inv_q = regs[int'(SEL_CTRL_INV)];
  assign cur_q      = regs[int'(SEL_CUR)];
  assign cur_inv_q  = regs[int'(SEL_CUR_INV)];

  assign ctrl_agree = ((ctrl_q ^ ctrl_inv_q) & CTRL_CHECK_MASK) == CTRL_CHECK_MASK;
  assign cur_agree  = &(cur_q ^ cur_inv_q);

  assign view.pair_ok  = ctrl_agree & cur_agree;
  assign view.cal_mode = &ctrl_q[CAL_HI:CAL_LO];
  assign view.range_hi = ctrl_q[RANGE_BIT];
  assign view.code     = cur_q;

endmodule

// File: rtl/laser_pin_sync.sv
module laser_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= 1'b0;
        else     chain[gi] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= 1'b0;
        else     chain[gi] <= chain[gi-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/laser_drive_seq.sv
module laser_drive_seq
  import laser_safety_pkg::*;
#(
  parameter int PULSE_LEN       = 4,
  parameter int SELFTEST_PERIOD = 64,
  parameter int TEST_WAIT       = 8,
  parameter int SETTLE_LEN      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_strobe,
  input  logic             shutdown,
  input  logic             pin_low_s,
  input  cfg_view_t        view,
  output logic             drive_en,
  output logic [REG_W-1:0] drive_code,
  output logic             drive_range_hi,
  output logic             supply_en_n,
  output logic             selftest_pull,
  output logic             fault_latched,
  output logic             cfg_mismatch
);

  localparam int MAX_A = (PULSE_LEN > TEST_WAIT) ? PULSE_LEN : TEST_WAIT;
  localparam int MAX_T = (MAX_A > SETTLE_LEN) ? MAX_A : SETTLE_LEN;
  localparam int TMR_W = $clog2(MAX_T + 1);
  localparam int FRM_W = $clog2(SELFTEST_PERIOD + 1);

  localparam logic [TMR_W-1:0] PULSE_LAST  = TMR_W'(PULSE_LEN - 1);
  localparam logic [TMR_W-1:0] WAIT_LAST   = TMR_W'(TEST_WAIT - 1);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_LEN - 1);
  localparam logic [FRM_W-1:0] FRM_LAST    = FRM_W'(SELFTEST_PERIOD - 1);

  seq_state_e       state_q, state_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [FRM_W-1:0] frm_q, frm_n;
  logic             fault_n, mism_n;
  logic             inhibit, in_test;
  logic             drive_d, supn_d, pull_d;

  assign inhibit = fault_latched | shutdown;
  assign in_test = (state_q == ST_TEST) | (state_q == ST_SETTLE);

  always_comb begin
    state_n = state_q;
    tmr_n   = tmr_q;
    frm_n   = frm_q;
    fault_n = fault_latched;
    mism_n  = cfg_mismatch;

    // pin reported low while the supply should be feeding it
    if (!shutdown && pin_low_s && !in_test) fault_n = 1'b1;

    if (inhibit) begin
      state_n = in_test ? ST_SETTLE : ST_IDLE;
      tmr_n   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (frame_strobe) begin
            if (frm_q == FRM_LAST) begin
              state_n = ST_TEST;
              tmr_n   = '0;
              frm_n   = '0;
            end else begin
              frm_n = frm_q + FRM_W'(1);
              if (!view.pair_ok) begin
                mism_n = 1'b1;
              end else if (!view.cal_mode) begin
                state_n = ST_PULSE;
                tmr_n   = '0;
              end
            end
          end
        end
        ST_PULSE: begin
          if (tmr_q == PULSE_LAST) state_n = ST_IDLE;
          else                     tmr_n   = tmr_q + TMR_W'(1);
        end
        ST_TEST: begin
          if (pin_low_s) begin
            state_n = ST_SETTLE;
            tmr_n   = '0;
          end else if (tmr_q == WAIT_LAST) begin
            fault_n = 1'b1;
            state_n = ST_IDLE;
            tmr_n   = '0;
          end else begin
            tmr_n = tmr_q + TMR_W'(1);
          end
        end
        default: begin
          if (tmr_q == SETTLE_LAST) state_n = ST_IDLE;
          else                      tmr_n   = tmr_q + TMR_W'(1);
        end
      endcase
    end

    drive_d = !fault_n && !shutdown && view.pair_ok &&
              ((state_n == ST_PULSE) || ((state_n == ST_IDLE) && view.cal_mode));
    supn_d  = fault_n || shutdown || (state_n == ST_TEST) || (state_n == ST_SETTLE);
    pull_d  = !fault_n && !shutdown && (state_n == ST_TEST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      tmr_q          <= '0;
      frm_q          <= '0;
      fault_latched  <= 1'b0;
      cfg_mismatch   <= 1'b0;
      drive_en       <= 1'b0;
      drive_code     <= '0;
      drive_range_hi <= 1'b0;
      supply_en_n    <= 1'b1;
      selftest_pull  <= 1'b0;
    end else begin
      state_q        <= state_n;
      tmr_q          <= tmr_n;
      frm_q          <= frm_n;
      fault_latched  <= fault_n;
      cfg_mismatch   <= mism_n;
      drive_en       <= drive_d;
      drive_code     <= drive_d ? view.code : '0;
      drive_range_hi <= drive_d & view.range_hi;
      supply_en_n    <= supn_d;
      selftest_pull  <= pull_d;
    end
  end

endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
  import laser_safety_pkg::*;
#(
  parameter int PULSE_LEN       = 4,
  parameter int SELFTEST_PERIOD = 64,
  parameter int TEST_WAIT       = 8,
  parameter int SYNC_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             frame_strobe,
  input  logic             shutdown,
  input  logic             pin_low,
  output logic             drive_en,
  output logic [REG_W-1:0] drive_code,
  output logic             drive_range_hi,
  output logic             supply_en_n,
  output logic             selftest_pull,
  output logic             fault_latched,
  output logic             cfg_mismatch
);

  // the pin must be quiet in sync before faults are watched again
  localparam int SETTLE_LEN = SYNC_STAGES + 1;

  cfg_view_t view;
  logic      pin_low_s;

  laser_cfg_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .view    (view)
  );

  laser_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_low),
    .dout (pin_low_s)
  );

  laser_drive_seq #(
    .PULSE_LEN       (PULSE_LEN),
    .SELFTEST_PERIOD (SELFTEST_PERIOD),
    .TEST_WAIT       (TEST_WAIT),
    .SETTLE_LEN      (SETTLE_LEN)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .frame_strobe   (frame_strobe),
    .shutdown       (shutdown),
    .pin_low_s      (pin_low_s),
    .view           (view),
    .drive_en       (drive_en),
    .drive_code     (drive_code),
    .drive_range_hi (drive_range_hi),
    .supply_en_n    (supply_en_n),
    .selftest_pull  (selftest_pull),
    .fault_latched  (fault_latched),
    .cfg_mismatch   (cfg_mismatch)
  );

endmodule

// File: rtl/laser_safety_chk.sv
module laser_safety_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_strobe,
  input logic       shutdown,
  input logic       drive_en,
  input logic [7:0] drive_code,
  input logic       drive_range_hi,
  input logic       supply_en_n,
  input logic       selftest_pull,
  input logic       fault_latched,
  input logic       cfg_mismatch
);

  p_fault_hold_r6: assert property (@(posedge clk) disable iff (rst)
    fault_latched |=> fault_latched);

  p_fault_off_r6: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> (supply_en_n && !drive_en));

  p_mism_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_mismatch |=> cfg_mismatch);

  p_mism_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mismatch) |-> $past(frame_strobe));

  p_shut_off_r9: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (supply_en_n && !drive_en && !selftest_pull));

  p_test_iso_r7: assert property (@(posedge clk) disable iff (rst)
    selftest_pull |-> (supply_en_n && !drive_en));

  p_code_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (drive_code == 8'h00 && !drive_range_hi));

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drive_en, selftest_pull}));

endmodule

bind laser_safety_ctrl laser_safety_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_strobe   (frame_strobe),
  .shutdown       (shutdown),
  .drive_en       (drive_en),
  .drive_code     (drive_code),
  .drive_range_hi (drive_range_hi),
  .supply_en_n    (supply_en_n),
  .selftest_pull  (selftest_pull),
  .fault_latched  (fault_latched),
  .cfg_mismatch   (cfg_mismatch)
);

// File: tb/laser_safety_ctrl_bench.sv
module laser_safety_ctrl_bench;

  localparam int PULSE_LEN = 4;
  localparam int PERIOD    = 4;
  localparam int TEST_WAIT = 8;
  localparam int SYNC      = 2;
  localparam int SETTLE    = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       frame_strobe = 1'b0;
  logic       shutdown = 1'b0;
  logic       inj = 1'b0;
  logic       stuck = 1'b0;
  logic       pin_low;
  logic       drive_en, drive_range_hi, supply_en_n, selftest_pull;
  logic       fault_latched, cfg_mismatch;
  logic [7:0] drive_code;

  // pin environment: follows the internal pull unless stuck, plus injected short
  assign pin_low = inj | (selftest_pull & ~stuck);

  always #10 clk = ~clk;

  laser_safety_ctrl #(
    .PULSE_LEN       (PULSE_LEN),
    .SELFTEST_PERIOD (PERIOD),
    .TEST_WAIT       (TEST_WAIT),
    .SYNC_STAGES     (SYNC)
  ) u_laser_safety_ctrl (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .wr_data        (wr_data),
    .frame_strobe   (frame_strobe),
    .shutdown       (shutdown),
    .pin_low        (pin_low),
    .drive_en       (drive_en),
    .drive_code     (drive_code),
    .drive_range_hi (drive_range_hi),
    .supply_en_n    (supply_en_n),
    .selftest_pull  (selftest_pull),
    .fault_latched  (fault_latched),
    .cfg_mismatch   (cfg_mismatch)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: modes 0 idle, 1 pulse, 2 test, 3 settle
  int m_reg [4];
  int m_mode, m_t, m_frm;
  bit m_fault, m_mism, m_valid;
  int pq [$];
  int e_drive, e_code, e_range, e_supn, e_pull;

  always @(posedge clk) begin
    int seen, ok, cal, ns, nt, nf, old_cur, old_rng, drv;
    bit nfault, nmism;
    m_valid = 1'b1;
    if (rst) begin
      m_reg[0] = 0; m_reg[1] = 1; m_reg[2] = 0; m_reg[3] = 0;
      m_mode = 0; m_t = 0; m_frm = 0; m_fault = 0; m_mism = 0;
      pq.delete();
      for (int i = 0; i < SYNC; i++) pq.push_back(0);
      e_drive = 0; e_code = 0; e_range = 0; e_supn = 1; e_pull = 0;
    end else begin
      seen = pq.pop_front();
      pq.push_back(pin_low ? 1 : 0);
      ok  = ((((m_reg[0] ^ m_reg[1]) & 'hAE) == 'hAE) &&
             (((m_reg[2] ^ m_reg[3]) & 'hFF) == 'hFF)) ? 1 : 0;
      cal = (((m_reg[0] >> 1) & 7) == 7) ? 1 : 0;
      old_cur = m_reg[2];
      old_rng = (m_reg[0] >> 7) & 1;
      if (wr_en) m_reg[wr_sel] = int'(wr_data);
      nfault = m_fault; nmism = m_mism; ns = m_mode; nt = m_t; nf = m_frm;
      if (!shutdown && seen != 0 && m_mode < 2) nfault = 1'b1;
      if (m_fault || shutdown) begin
        ns = (m_mode >= 2) ? 3 : 0;
        nt = 0;
      end else begin
        case (m_mode)
          0: if (frame_strobe) begin
               if (m_frm == PERIOD - 1) begin ns = 2; nt = 0; nf = 0; end
               else begin
                 nf = m_frm + 1;
                 if (ok == 0) nmism = 1'b1;
                 else if (cal == 0) begin ns = 1; nt = 0; end
               end
             end
          1: if (m_t == PULSE_LEN - 1) ns = 0; else nt = m_t + 1;
          2: if (seen != 0) begin ns = 3; nt = 0; end
             else if (m_t == TEST_WAIT - 1) begin nfault = 1'b1; ns = 0; nt = 0; end
             else nt = m_t + 1;
          default: if (m_t == SETTLE - 1) ns = 0; else nt = m_t + 1;
        endcase
      end
      drv = (!nfault && !shutdown && ok != 0 && (ns == 1 || (ns == 0 && cal != 0))) ? 1 : 0;
      e_drive = drv;
      e_code  = drv ? old_cur : 0;
      e_range = drv ? old_rng : 0;
      e_supn  = (nfault || shutdown || ns == 2 || ns == 3) ? 1 : 0;
      e_pull  = (!nfault && !shutdown && ns == 2) ? 1 : 0;
      m_mode = ns; m_t = nt; m_frm = nf; m_fault = nfault; m_mism = nmism;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check("R3",  "drive_en",       int'(drive_en),       e_drive);
      check("R10", "drive_code",     int'(drive_code),     e_code);
      check("R3",  "drive_range_hi", int'(drive_range_hi), e_range);
      check("R6",  "supply_en_n",    int'(supply_en_n),    e_supn);
      check("R7",  "selftest_pull",  int'(selftest_pull),  e_pull);
      check("R6",  "fault_latched",  int'(fault_latched),  int'(m_fault));
      check("R5",  "cfg_mismatch",   int'(cfg_mismatch),   int'(m_mism));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog cycles=%0d limit=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // r1_ reset values
    idle(3);
    check("R1", "reset supply_en_n", int'(supply_en_n), 1);
    check("R1", "reset drive_en", int'(drive_en), 0);
    check("R1", "reset fault", int'(fault_latched), 0);
    rst = 1'b0;
    idle(1);
    check("R1", "supply on after release", int'(supply_en_n), 0);

    // R2 reset pairs disagree; R5 refused frame sets sticky flag (frame 1)
    strobe();
    check("R2", "no drive with default pairs", int'(drive_en), 0);
    check("R5", "mismatch set", int'(cfg_mismatch), 1);

    // R3 pulsed drive (frames 2, 3)
    wr(0, 'hA0); wr(1, 'h5F); wr(2, 'h3C); wr(3, 'hC3);
    strobe();
    check("R3", "pulse start", int'(drive_en), 1);
    check("R3", "pulse code", int'(drive_code), 'h3C);
    check("R3", "pulse range", int'(drive_range_hi), 1);
    idle(PULSE_LEN - 1);
    check("R3", "last pulse cycle", int'(drive_en), 1);
    idle(1);
    check("R3", "pulse ended", int'(drive_en), 0);
    check("R10", "code idle", int'(drive_code), 0);
    idle(10);
    strobe();
    check("R3", "second pulse", int'(drive_en), 1);
    idle(10);

    // R7 self-test on frame 4 with a responding pin
    strobe();
    check("R7", "pull asserted", int'(selftest_pull), 1);
    check("R7", "supply off in test", int'(supply_en_n), 1);
    check("R7", "no drive in test", int'(drive_en), 0);
    idle(20);
    check("R7", "supply back on", int'(supply_en_n), 0);
    check("R7", "no fault after pass", int'(fault_latched), 0);

    // R2 bin bit not inverted; then R5 resume
    wr(1, 'h7F);
    strobe();
    check("R2", "bin bit disagree blocks drive", int'(drive_en), 0);
    wr(1, 'h5F);
    strobe();
    check("R5", "drive resumes on agreement", int'(drive_en), 1);
    check("R5", "mismatch still set", int'(cfg_mismatch), 1);
    idle(10);

    // R4 calibration drive
    wr(0, 'hAE); wr(1, 'h51);
    idle(1);
    check("R4", "continuous drive on", int'(drive_en), 1);
    idle(6);
    check("R4", "continuous drive held", int'(drive_en), 1);
    check("R4", "continuous code", int'(drive_code), 'h3C);

    // R9 shutdown
    shutdown = 1'b1;
    idle(1);
    check("R9", "drive off in shutdown", int'(drive_en), 0);
    check("R9", "supply off in shutdown", int'(supply_en_n), 1);
    strobe();
    check("R9", "strobe ignored in shutdown", int'(drive_en), 0);
    shutdown = 1'b0;
    idle(1);
    check("R9", "drive back after shutdown", int'(drive_en), 1);

    // R8 self-test with pin stuck high
    wr(0, 'hA0); wr(1, 'h5F);
    stuck = 1'b1;
    for (int k = 0; k < PERIOD; k++) begin
      idle(20);
      strobe();
    end
    idle(20);
    check("R8", "fault on missing response", int'(fault_latched), 1);
    check("R8", "supply off after fault", int'(supply_en_n), 1);
    strobe();
    check("R6", "no pulse after fault", int'(drive_en), 0);

    // R6 injected short while idle
    rst = 1'b1;
    idle(2);
    check("R1", "fault cleared by reset", int'(fault_latched), 0);
    check("R1", "mismatch cleared by reset", int'(cfg_mismatch), 0);
    rst = 1'b0;
    stuck = 1'b0;
    wr(0, 'hA0); wr(1, 'h5F); wr(2, 'h11); wr(3, 'hEE);
    idle(3);
    inj = 1'b1;
    idle(SYNC + 2);
    check("R6", "fault on pin low", int'(fault_latched), 1);
    check("R6", "supply off on fault", int'(supply_en_n), 1);
    inj = 1'b0;
    idle(5);
    check("R6", "fault stays latched", int'(fault_latched), 1);
    strobe();
    check("R6", "no drive while faulted", int'(drive_en), 0);

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule